// File: doc/BRIEF.md
# Accumulator Processor Fetch-Execute Core

This block is a small 8-bit accumulator processor with a 16-bit address space and one shared memory port, so that instructions and data come through the same path. A program counter walks memory one byte at a time. The core captures the opcode, then gathers any operand bytes, forms an effective address where the addressing mode calls for one, and finally loads, adds or stores accumulator A. Arithmetic and load results update a condition-code register.

The memory port is synchronous. An address is presented in one cycle and the read byte comes back in the next cycle. A write is a single cycle with the write enable high. Four addressing forms are handled. Extended gives a full two-byte address, high byte first. Direct gives a one-byte address inside page zero, where a page is the 256 bytes sharing one high address byte. Immediate takes the data from the operand byte. Inherent takes its data from registers. An opcode outside the supported set stops the core until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and right after it, the core presents START_ADDR (default 0x0100) on the address port with write enable low, halted low, A = 0x00 and the flag register = 0x00. The flag register holds C at bit 0, V at bit 1, Z at bit 2 and N at bit 3, and bits 7:4 always read zero.
- R2: The program counter advances by exactly one for each byte fetched (opcode or operand) and stays put in every other cycle, so each instruction begins at the byte after the previous instruction's last operand.
- R3: Load A (0x86 immediate, 0x96 direct, 0xB6 extended) copies the byte into A, sets N from bit 7, sets Z when the byte is zero, clears V and leaves C unchanged.
- R4: Direct mode (0x96, 0x9B, 0x97) forms the address {0x00, operand}, so only page zero is reachable.
- R5: Extended mode (0xB6, 0xBB, 0xB7) forms the address from the two operand bytes, with the first byte as the high byte.
- R6: Add to A (0x8B immediate, 0x9B direct, 0xBB extended) writes the 8-bit sum into A. C is the carry out of bit 7, V is signed overflow, N is bit 7 of the sum and Z is set when the sum is zero.
- R7: Store A (0x97 direct, 0xB7 extended) writes A to the effective address in exactly one write cycle and leaves A and the flags unchanged.
- R8: Opcode 0x1B adds register B to A, with flags as in R6. B holds the reset value B_RESET (default 0x05). The instruction makes no memory access beyond its opcode fetch.
- R9: Opcode 0x01 changes no register other than the program counter.
- R10: Any other opcode raises halted. Halted stays high until reset, and after it no further writes occur and the address port no longer moves.
- R11: Each read waits one cycle for its data. Instruction lengths in clocks: 0x01 and 0x1B take 2, immediate forms take 4, direct load/add take 6, direct store takes 5, extended load/add take 8 and extended store takes 7. A bad opcode raises halted 2 clocks after its fetch starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data (accumulator A) |
| mem_we | output | 1 | Write enable, one cycle per store |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| halted | output | 1 | High once an unsupported opcode is seen |
| acc_o | output | 8 | Accumulator A |
| ccr_o | output | 8 | Condition-code flags |

## Verification
Some properties are checked by the assertions on every clock:
- the program counter steps only in byte-capture states;
- a direct-mode data access stays in page zero;
- A changes only on an execute strobe;
- the carry flag after an add matches the 9-bit sum of the previous operands;
- Z agrees with A after a load or add;
- halted is sticky and never coincides with a write.

Other behaviour only the directed scenarios can show:
- the exact instruction lengths in clocks;
- the high-byte-first order of extended addresses;
- that a load leaves C alone and a store leaves the flags alone;
- that the bad-opcode stop leaves the program counter just past the offending byte.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = ADDR_W - DATA_W;

  // condition-code bit positions
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;

  typedef enum logic [3:0] {
    ST_FETCH, ST_OPC, ST_OP1, ST_OP1W, ST_OP2, ST_OP2W,
    ST_EXEC, ST_EXECW, ST_HALT
  } cpu_state_e;

  typedef enum logic [2:0] {K_NOP, K_ABA, K_LDA, K_ADD, K_STA} op_kind_e;
  typedef enum logic [1:0] {M_INH, M_IMM, M_DIR, M_EXT} addr_mode_e;

  typedef struct packed {
    logic       valid;
    op_kind_e   kind;
    addr_mode_e mode;
  } op_dec_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] cc;
  } alu_out_t;

  function automatic op_dec_t decode_op(input logic [DATA_W-1:0] op);
    op_dec_t d;
    d = '{valid: 1'b1, kind: K_NOP, mode: M_INH};
    case (op)
      8'h01: d = '{1'b1, K_NOP, M_INH};
      8'h1B: d = '{1'b1, K_ABA, M_INH};
      8'h86: d = '{1'b1, K_LDA, M_IMM};
      8'h96: d = '{1'b1, K_LDA, M_DIR};
      8'hB6: d = '{1'b1, K_LDA, M_EXT};
      8'h8B: d = '{1'b1, K_ADD, M_IMM};
      8'h9B: d = '{1'b1, K_ADD, M_DIR};
      8'hBB: d = '{1'b1, K_ADD, M_EXT};
      8'h97: d = '{1'b1, K_STA, M_DIR};
      8'hB7: d = '{1'b1, K_STA, M_EXT};
      default: d = '{1'b0, K_NOP, M_INH};
    endcase
    return d;
  endfunction

  function automatic alu_out_t alu_add(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    alu_out_t o;
    logic [DATA_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    o.res = wide[DATA_W-1:0];
    o.cc = '0;
    o.cc[CC_C] = wide[DATA_W];
    o.cc[CC_V] = (a[DATA_W-1] == b[DATA_W-1]) && (o.res[DATA_W-1] != a[DATA_W-1]);
    o.cc[CC_Z] = (o.res == '0);
    o.cc[CC_N] = o.res[DATA_W-1];
    return o;
  endfunction

  function automatic alu_out_t alu_load(input logic [DATA_W-1:0] d,
                                        input logic [DATA_W-1:0] cc_in);
    alu_out_t o;
    o.res = d;
    o.cc = '0;
    o.cc[CC_C] = cc_in[CC_C];
    o.cc[CC_Z] = (d == '0);
    o.cc[CC_N] = d[DATA_W-1];
    return o;
  endfunction

endpackage

// File: rtl/acc_cpu_addr_gen.sv
module acc_cpu_addr_gen
  import acc_cpu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  cpu_state_e           state,
  input  addr_mode_e           mode,
  input  logic [ADDR_W-1:0]    pc,
  input  logic [PAGE_W-1:0]    ea_hi,
  input  logic [DATA_W-1:0]    ea_lo,
  output logic [ADDR_W-1:0]    addr
);

  logic data_phase;
  assign data_phase = (state == ST_EXEC) || (state == ST_EXECW);

  always_comb begin
    addr = pc;
    if (data_phase) begin
      if (mode == M_EXT) addr = {ea_hi, ea_lo};
      else               addr = {{PAGE_W{1'b0}}, ea_lo};
    end
  end

  AST_DIRECT_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && mode == M_DIR) |-> (addr[ADDR_W-1:DATA_W] == '0)); // R4

  AST_EXT_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && mode == M_EXT) |-> (addr[DATA_W-1:0] == ea_lo)); // R5

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h0100
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  rdata,
  output cpu_state_e         state,
  output addr_mode_e         cur_mode,
  output logic [ADDR_W-1:0]  pc,
  output logic [PAGE_W-1:0]  ea_hi,
  output logic [DATA_W-1:0]  ea_lo,
  output logic               mem_we,
  output logic               halted,
  output logic               exec_fire,
  output op_kind_e           exec_kind
);

  cpu_state_e        state_q, state_d;
  op_dec_t           ir_q, ir_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [PAGE_W-1:0] hi_q, hi_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  op_dec_t           fresh;

  // named events for the checks
  logic byte_capture;
  logic is_store_cycle;

  assign fresh = decode_op(rdata);
  assign byte_capture = (state_q == ST_OPC) || (state_q == ST_OP1W) || (state_q == ST_OP2W);
  assign is_store_cycle = (state_q == ST_EXEC) && (ir_q.kind == K_STA);

  always_comb begin
    state_d = state_q;
    ir_d    = ir_q;
    pc_d    = pc_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_OPC;
      ST_OPC: begin
        ir_d = fresh;
        pc_d = pc_q + 1'b1;
        if (!fresh.valid)                                   state_d = ST_HALT;
        else if (fresh.kind == K_NOP || fresh.kind == K_ABA) state_d = ST_FETCH;
        else                                                 state_d = ST_OP1;
      end
      ST_OP1: state_d = ST_OP1W;
      ST_OP1W: begin
        pc_d = pc_q + 1'b1;
        case (ir_q.mode)
          M_DIR: begin lo_d = rdata; state_d = ST_EXEC; end
          M_EXT: begin hi_d = rdata; state_d = ST_OP2; end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_OP2: state_d = ST_OP2W;
      ST_OP2W: begin
        pc_d = pc_q + 1'b1;
        lo_d = rdata;
        state_d = ST_EXEC;
      end
      ST_EXEC:  state_d = (ir_q.kind == K_STA) ? ST_FETCH : ST_EXECW;
      ST_EXECW: state_d = ST_FETCH;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '{1'b1, K_NOP, M_INH};
      pc_q    <= START_ADDR;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      ir_q    <= ir_d;
      pc_q    <= pc_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  always_comb begin
    exec_fire = 1'b0;
    exec_kind = ir_q.kind;
    if (state_q == ST_OPC) begin
      exec_kind = fresh.kind;
      exec_fire = fresh.valid && (fresh.kind == K_ABA);
    end else if (state_q == ST_OP1W) begin
      exec_fire = (ir_q.mode == M_IMM);
    end else if (state_q == ST_EXECW) begin
      exec_fire = 1'b1;
    end
  end

  assign state    = state_q;
  assign cur_mode = ir_q.mode;
  assign pc       = pc_q;
  assign ea_hi    = hi_q;
  assign ea_lo    = lo_q;
  assign mem_we   = is_store_cycle;
  assign halted   = (state_q == ST_HALT);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_capture |=> (pc_q == $past(pc_q) + 16'd1)); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_capture |=> $stable(pc_q)); // R2

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we); // R10

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R7

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter logic [DATA_W-1:0] B_RESET = 8'h05
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  op_kind_e           kind,
  input  logic [DATA_W-1:0]  opnd,
  output logic [DATA_W-1:0]  acc,
  output logic [DATA_W-1:0]  ccr
);

  logic [DATA_W-1:0] acc_q, cc_q, b_q;
  alu_out_t          nxt;
  logic              writes_acc;

  always_comb begin
    nxt = '{res: acc_q, cc: cc_q};
    writes_acc = 1'b0;
    case (kind)
      K_LDA: begin nxt = alu_load(opnd, cc_q); writes_acc = 1'b1; end
      K_ADD: begin nxt = alu_add(acc_q, opnd);  writes_acc = 1'b1; end
      K_ABA: begin nxt = alu_add(acc_q, b_q);   writes_acc = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cc_q  <= '0;
      b_q   <= B_RESET;
    end else if (fire && writes_acc) begin
      acc_q <= nxt.res;
      cc_q  <= nxt.cc;
    end
  end

  assign acc = acc_q;
  assign ccr = cc_q;

  AST_ACC_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(acc_q) && $stable(cc_q))); // R7

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == K_ADD) |=>
      (cc_q[CC_C] == (({1'b0, $past(acc_q)} + {1'b0, $past(opnd)}) > 9'd255))); // R6

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (kind == K_LDA || kind == K_ADD || kind == K_ABA)) |=>
      (cc_q[CC_Z] == (acc_q == '0))); // R3

  AST_LOAD_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == K_LDA) |=> (cc_q[CC_C] == $past(cc_q[CC_C]) && !cc_q[CC_V])); // R3

  AST_UPPER_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cc_q[DATA_W-1:4] == '0); // R1

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter logic [15:0] START_ADDR = 16'h0100,
  parameter logic [7:0]  B_RESET    = 8'h05
)(
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic        halted,
  output logic [7:0]  acc_o,
  output logic [7:0]  ccr_o
);

  cpu_state_e        state;
  addr_mode_e        cur_mode;
  logic [ADDR_W-1:0] pc;
  logic [PAGE_W-1:0] ea_hi;
  logic [DATA_W-1:0] ea_lo;
  logic              exec_fire;
  op_kind_e          exec_kind;

  acc_cpu_ctrl #(.START_ADDR(START_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdata     (mem_rdata),
    .state     (state),
    .cur_mode  (cur_mode),
    .pc        (pc),
    .ea_hi     (ea_hi),
    .ea_lo     (ea_lo),
    .mem_we    (mem_we),
    .halted    (halted),
    .exec_fire (exec_fire),
    .exec_kind (exec_kind)
  );

  acc_cpu_addr_gen u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .mode  (cur_mode),
    .pc    (pc),
    .ea_hi (ea_hi),
    .ea_lo (ea_lo),
    .addr  (mem_addr)
  );

  acc_cpu_datapath #(.B_RESET(B_RESET)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (exec_fire),
    .kind  (exec_kind),
    .opnd  (mem_rdata),
    .acc   (acc_o),
    .ccr   (ccr_o)
  );

  assign mem_wdata = acc_o;

  AST_WRITE_DATA_IS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (acc_o == $past(mem_wdata))); // R7

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;

  localparam logic [15:0] START = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        halted;
  logic [7:0]  acc_o;
  logic [7:0]  ccr_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [0:2047];
  int          wr_count;
  logic [15:0] last_waddr;
  logic [7:0]  last_wdata;

  always #10 clk = ~clk;

  acc_cpu_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .acc_o(acc_o), .ccr_o(ccr_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_count <= 0;
    end else if (mem_we) begin
      mem[mem_addr[10:0]] <= mem_wdata;
      wr_count   <= wr_count + 1;
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[10:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] v);
    mem[a[10:0]] = v;
  endtask

  task automatic run(output int cycles);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cycles = 0;
    while (!halted && cycles < 400) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    clear_mem();
    @(posedge clk);
    @(negedge clk);
    chk("R1 addr", mem_addr, START);
    chk("R1 we", mem_we, 0);
    chk("R1 halted", halted, 0);
    chk("R1 acc", acc_o, 0);
    chk("R1 ccr", ccr_o, 0);
  endtask

  task automatic t_nop_halt();
    int c;
    logic [15:0] a0;
    clear_mem();
    put(START, 8'h01); put(START + 1, 8'hFF);
    run(c);
    chk("R9/R11 nop cycles", c, 4);
    chk("R10 halted", halted, 1);
    chk("R2 pc after halt", mem_addr, START + 2);
    chk("R9 acc", acc_o, 0);
    chk("R9 ccr", ccr_o, 0);
    a0 = mem_addr;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R10 sticky", halted, 1);
    chk("R10 addr frozen", mem_addr, a0);
    chk("R10 no writes", wr_count, 0);
  endtask

  task automatic t_imm_load();
    int c;
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'h80); put(START + 2, 8'hFF);
    run(c);
    chk("R11 imm cycles", c, 6);
    chk("R3 acc", acc_o, 8'h80);
    chk("R3 N flag", ccr_o, 8'h08);
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'h00); put(START + 2, 8'hFF);
    run(c);
    chk("R3 Z flag", ccr_o, 8'h04);
  endtask

  task automatic t_add_flags();
    int c;
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'h7F); put(START + 2, 8'h8B); put(START + 3, 8'h01);
    put(START + 4, 8'hFF);
    run(c);
    chk("R11 two imm cycles", c, 10);
    chk("R6 overflow sum", acc_o, 8'h80);
    chk("R6 N V", ccr_o, 8'h0A);
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'h80); put(START + 2, 8'h8B); put(START + 3, 8'h80);
    put(START + 4, 8'hFF);
    run(c);
    chk("R6 wrap sum", acc_o, 8'h00);
    chk("R6 C V Z", ccr_o, 8'h07);
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'hFF); put(START + 2, 8'h8B); put(START + 3, 8'h01);
    put(START + 4, 8'h86); put(START + 5, 8'h05); put(START + 6, 8'hFF);
    run(c);
    chk("R3 load value", acc_o, 8'h05);
    chk("R3 load keeps C", ccr_o, 8'h01);
  endtask

  task automatic t_direct();
    int c;
    clear_mem();
    put(16'h0040, 8'h22); put(16'h0041, 8'h11);
    put(16'h0140, 8'h99); put(16'h0141, 8'h99);
    put(START, 8'h96); put(START + 1, 8'h40);
    put(START + 2, 8'h9B); put(START + 3, 8'h41);
    put(START + 4, 8'h97); put(START + 5, 8'h42);
    put(START + 6, 8'hFF);
    run(c);
    chk("R11 direct cycles", c, 19);
    chk("R4 direct sum", acc_o, 8'h33);
    chk("R6 flags clear", ccr_o, 8'h00);
    chk("R4 store addr", last_waddr, 16'h0042);
    chk("R7 stored byte", mem[16'h0042], 8'h33);
    chk("R7 one write", wr_count, 1);
    chk("R2 pc end", mem_addr, START + 7);
  endtask

  task automatic t_extended();
    int c;
    clear_mem();
    put(16'h0510, 8'h40); put(16'h0511, 8'h50);
    put(16'h0005, 8'h77); put(16'h0105, 8'h77);
    put(START, 8'hB6); put(START + 1, 8'h05); put(START + 2, 8'h10);
    put(START + 3, 8'hBB); put(START + 4, 8'h05); put(START + 5, 8'h11);
    put(START + 6, 8'hB7); put(START + 7, 8'h06); put(START + 8, 8'h34);
    put(START + 9, 8'hFF);
    run(c);
    chk("R11 extended cycles", c, 25);
    chk("R5 ext sum", acc_o, 8'h90);
    chk("R7 store keeps flags", ccr_o, 8'h0A);
    chk("R5 store addr", last_waddr, 16'h0634);
    chk("R7 store data", last_wdata, 8'h90);
    chk("R7 one write", wr_count, 1);
  endtask

  task automatic t_aba();
    int c;
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'hFE); put(START + 2, 8'h1B); put(START + 3, 8'hFF);
    run(c);
    chk("R8/R11 cycles", c, 8);
    chk("R8 acc", acc_o, 8'h03);
    chk("R8 carry", ccr_o, 8'h01);
    chk("R8 no write", wr_count, 0);
  endtask

  task automatic t_bad_opcode();
    int c;
    clear_mem();
    put(START, 8'h86); put(START + 1, 8'h11); put(START + 2, 8'h87);
    put(START + 3, 8'h22); put(START + 4, 8'h86); put(START + 5, 8'h33);
    run(c);
    chk("R10/R11 halt cycles", c, 6);
    chk("R10 acc kept", acc_o, 8'h11);
    chk("R10 stop point", mem_addr, START + 3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 no write", wr_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_nop_halt();
    t_imm_load();
    t_add_flags();
    t_direct();
    t_extended();
    t_aba();
    t_bad_opcode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule